// File: doc/BRIEF.md
# Precision-Scalable Signed Multiplier

This block multiplies two 16-bit two's-complement operands and can drop, at run time, to an 8-bit precision in which only the upper byte of each operand is used. A single signed partial-product array serves both precisions. In the reduced mode the low byte of each operand is forced to zero where it is captured. The lower part of the array therefore sees constant inputs and does not switch. The 8-bit result appears in the upper half of the array's output, and a byte-routing stage moves it down to the low half of the result port.

An operation starts when `in_valid` is high. On that edge the operands and the precision select are captured together, with the low bytes already zeroed if the reduced mode is chosen. One clock later `out_valid` pulses and `prod` holds the result. In the cycles that follow, `prod` stays unchanged until the next valid operation.

Top module: `prec_scal_mul`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `prod` is 0.
- R2: With `half_prec` = 0, `prod` is the signed 32-bit product of `op_x` and `op_y`. It is presented one clock after the edge on which `in_valid` was high.
- R3: With `half_prec` = 1, `prod[15:0]` is the signed 16-bit product of `op_x[15:8]` and `op_y[15:8]`, and `prod[31:16]` copies bit 15 of that product (sign extension).
- R4: With `half_prec` = 1, the values of `op_x[7:0]` and `op_y[7:0]` have no effect on `prod`.
- R5: `out_valid` is high in a cycle exactly when `in_valid` was high on the previous clock edge. Back-to-back operations are accepted one per cycle.
- R6: While `in_valid` is low, `prod` does not change, whatever `op_x` and `op_y` do.
- R7: `half_prec` is captured only together with valid operands. A change of `half_prec` while `in_valid` is low does not alter `prod`, and it applies from the next valid operation.
- R8: The extreme operands give exact results: -32768 × -32768 gives 1073741824 in full mode, and -128 × -128 gives 16384 in reduced mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and precision select are valid this cycle |
| half_prec | input | 1 | 1 = 8-bit precision on the upper bytes, 0 = full 16-bit precision |
| op_x | input | 16 | Multiplicand, two's complement |
| op_y | input | 16 | Multiplier, two's complement |
| out_valid | output | 1 | Result valid, one cycle after the operation was accepted |
| prod | output | 32 | Signed product, held until the next operation |

## Verification
The assertions assume `rst` is high for at least one edge before the first operation. They also assume every input has a defined 0/1 value at each rising edge, so that checks based on `$past` compare real operand values. The bench drives all inputs on the falling edge, starts with a reset pulse of several cycles, and never leaves an input undefined. It changes operands and the precision select during idle cycles on purpose, because the hold checks depend on that stimulus being present.

// File: rtl/psm_pkg.sv
package psm_pkg;

    // Default operand width of the multiplier
    localparam int OPW = 16;

    // Precision select encoding on the half_prec pin
    typedef enum logic {
        PREC_FULL = 1'b0,
        PREC_HALF = 1'b1
    } prec_e;

endpackage

// File: rtl/psm_bw_array.sv
// Signed W x W array multiplier in modified Baugh-Wooley form.
// Each row is one partial product. The sign-row cross terms are inverted,
// and a constant (2^W + 2^(2W-1)) seeds the accumulation chain.
module psm_bw_array #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc [0:W];

    // Correction constant of the modified scheme
    assign acc[0] = (PW'(1) << W) | (PW'(1) << (PW - 1));

    for (genvar j = 0; j < W; j++) begin : g_row
        logic [PW-1:0] row;

        always_comb begin
            row = '0;
            for (int i = 0; i < W; i++) begin
                if ((i == W - 1) != (j == W - 1)) begin
                    row[i + j] = ~(a[i] & b[j]);
                end else begin
                    row[i + j] = a[i] & b[j];
                end
            end
        end

        assign acc[j + 1] = acc[j] + row;
    end

    assign p = acc[W];

endmodule

// File: rtl/psm_route.sv
// Output routing: in reduced precision, the upper half of the array result
// holds the short product. It is moved to the low half and sign-extended.
module psm_route #(
    parameter int W = 16
) (
    input  logic           half,
    input  logic [2*W-1:0] arr_p,
    output logic [2*W-1:0] z
);
    localparam int PW = 2 * W;

    logic [W-1:0] upper;
    assign upper = arr_p[PW-1:W];

    always_comb begin
        if (half) begin
            z = {{W{upper[W-1]}}, upper};
        end else begin
            z = arr_p;
        end
    end

endmodule

// File: rtl/prec_scal_mul.sv
module prec_scal_mul #(
    parameter int W = psm_pkg::OPW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             half_prec,
    input  logic [W-1:0]     op_x,
    input  logic [W-1:0]     op_y,
    output logic             out_valid,
    output logic [2*W-1:0]   prod
);
    import psm_pkg::*;

    localparam int HW = W / 2;
    localparam int PW = 2 * W;

    typedef struct packed {
        logic         vld;
        prec_e        prec;
        logic [W-1:0] x;
        logic [W-1:0] y;
    } stage_t;

    stage_t st_d, st_q;
    logic [PW-1:0] arr_p;

    // Next-state: operands are captured only with valid, low bytes gated in half mode
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prec = prec_e'(half_prec);
            if (half_prec) begin
                st_d.x = {op_x[W-1:HW], {HW{1'b0}}};
                st_d.y = {op_y[W-1:HW], {HW{1'b0}}};
            end else begin
                st_d.x = op_x;
                st_d.y = op_y;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{vld: 1'b0, prec: PREC_FULL, x: '0, y: '0};
        end else begin
            st_q <= st_d;
        end
    end

    psm_bw_array #(.W(W)) i_array (
        .a (st_q.x),
        .b (st_q.y),
        .p (arr_p)
    );

    psm_route #(.W(W)) i_route (
        .half  (st_q.prec == PREC_HALF),
        .arr_p (arr_p),
        .z     (prod)
    );

    assign out_valid = st_q.vld;

endmodule

// File: rtl/prec_scal_mul_chk.sv
module prec_scal_mul_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           half_prec,
    input logic [W-1:0]   op_x,
    input logic [W-1:0]   op_y,
    input logic           out_valid,
    input logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    localparam int HW = W / 2;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && prod == '0));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6
    hold_prod_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prod));

    // R2
    full_value_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !half_prec) |=>
            ($signed(prod) == PW'($signed($past(op_x)) * $signed($past(op_y)))));

    // R3
    half_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_prec) |=>
            ($countones(prod[PW-1:W-1]) == 0 || $countones(prod[PW-1:W-1]) == W + 1));

    // R3
    half_value_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_prec) |=>
            ($signed(prod[W-1:0]) ==
             W'($signed($past(op_x[W-1:HW])) * $signed($past(op_y[W-1:HW])))));

endmodule

bind prec_scal_mul prec_scal_mul_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .half_prec (half_prec),
    .op_x      (op_x),
    .op_y      (op_y),
    .out_valid (out_valid),
    .prod      (prod)
);

// File: tb/test_prec_scal_mul.sv
`timescale 1ns/1ps
module test_prec_scal_mul;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        half_prec;
    logic [15:0] op_x;
    logic [15:0] op_y;
    logic        out_valid;
    logic [31:0] prod;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prec_scal_mul i_prec_scal_mul (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .half_prec (half_prec),
        .op_x      (op_x),
        .op_y      (op_y),
        .out_valid (out_valid),
        .prod      (prod)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_full(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] r;
        r = 32'($signed(x)) * 32'($signed(y));
        return r;
    endfunction

    function automatic logic [31:0] exp_half(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] r;
        r = 32'($signed(x[15:8])) * 32'($signed(y[15:8]));
        return r;
    endfunction

    // Issue one operation at a falling edge, sample one cycle later
    task automatic issue(input logic h, input logic [15:0] x, input logic [15:0] y, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        half_prec = h;
        op_x      = x;
        op_y      = y;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check(req, prod, h ? exp_half(x, y) : exp_full(x, y));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; half_prec = 1'b0; op_x = '0; op_y = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 prod", prod, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {31'd0, out_valid} | prod, 32'd0);
    endtask

    task automatic t_full();
        issue(1'b0, 16'd3, 16'd7, "R2 small");
        issue(1'b0, 16'hFFFF, 16'd1234, "R2 neg x");
        issue(1'b0, 16'd32767, 16'h8001, "R2 mixed");
        issue(1'b0, 16'h1234, 16'hABCD, "R2 pattern");
        issue(1'b0, 16'h8000, 16'h8000, "R8 full extreme");
        issue(1'b0, 16'h8000, 16'h7FFF, "R2 min*max");
    endtask

    task automatic t_half();
        issue(1'b1, 16'h0500, 16'h0900, "R3 small");
        issue(1'b1, 16'hFD00, 16'h0700, "R3 negative");
        issue(1'b1, 16'h8000, 16'h8000, "R8 half extreme");
        issue(1'b1, 16'h7F00, 16'h8000, "R3 max*min");
    endtask

    task automatic t_lowbytes();
        logic [31:0] ref_p;
        issue(1'b1, 16'h1300, 16'hE500, "R4 base");
        ref_p = prod;
        issue(1'b1, 16'h13FF, 16'hE5A7, "R4 junk low bytes");
        check("R4 same as base", prod, ref_p);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        issue(1'b0, 16'd1000, 16'hFF38, "R6 setup");
        held = prod;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_x = 16'h5A5A + 16'(k);
            op_y = 16'hC3C3 - 16'(k);
        end
        check("R6 held", prod, held);
        check("R5 idle valid", 32'(out_valid), 32'd0);
    endtask

    task automatic t_mode();
        logic [31:0] held;
        issue(1'b0, 16'h0203, 16'h0405, "R7 setup");
        held = prod;
        @(negedge clk);
        half_prec = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 mode flip ignored", prod, held);
        issue(1'b1, 16'h0203, 16'h0405, "R7 new mode applies");
    endtask

    task automatic t_b2b();
        @(negedge clk);
        in_valid = 1'b1; half_prec = 1'b0; op_x = 16'd300; op_y = 16'hFFF6;
        @(negedge clk);
        check("R5 b2b first", prod, exp_full(16'd300, 16'hFFF6));
        half_prec = 1'b1; op_x = 16'hF6AA; op_y = 16'h0C55;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 b2b valid", 32'(out_valid), 32'd1);
        check("R5 b2b second", prod, exp_half(16'hF6AA, 16'h0C55));
        @(negedge clk);
        check("R5 drop", 32'(out_valid), 32'd0);
    endtask

    initial begin
        t_reset();
        t_full();
        t_half();
        t_lowbytes();
        t_hold();
        t_mode();
        t_b2b();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule